// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block derives the clocks of an audio serial port from a single kernel clock. Software writes an 8-bit prescale field and an odd-adjust bit; together they set a division ratio of twice the prescale value plus the odd bit. The divided clock either serves directly as the bit clock, or it is driven out as a master clock. In the second case a fixed post-divider makes the bit clock from it. A frame counter then produces the frame (word-select) clock. Its frame length and shape come from a channel-length bit and a format bit that selects between two-slot framing and a DSP-style single-pulse framing.

All outputs are levels held in registers in the kernel clock domain. Configuration fields are captured only while the port is disabled. One illegal prescale/odd pair raises an error flag and keeps the clocks quiet. While the port is idle, a park control either forces the clock outputs low or holds their last levels.

Top module: `aud_clk_div`

## Requirements
- R1: The synchronous active-high reset drives mclk_o, bclk_o, fsync_o and cfg_err_o low at the next clock edge.
- R2: The division ratio N is 2*pre_i + odd_i (pre_i unsigned). The divided clock is high for ceil(N/2) kernel cycles and low for floor(N/2) kernel cycles, so an odd N gets the extra cycle in its high phase.
- R3: A setting of pre_i=0 with odd_i=0 gives ratio one, and so does pre_i=0 with odd_i=1. At ratio one the registered divided level stays constantly high, and the bit clock advances on every kernel cycle.
- R4: pre_i=1 with odd_i=1 is illegal. cfg_err_o goes high one edge after this pair is presented while port_en_i is low. While the flag is set, no clock output toggles. Any other pair, for example pre_i=1 with odd_i=0, leaves the flag low.
- R5: With mclk_en_i=1, mclk_o carries the divided clock. bclk_o is then the divided clock further divided by P, with equal high and low halves. P is 8 when wide_i=0 and 4 when wide_i=1, in both frame formats. This ratio gives 256 master cycles per frame in two-slot format and 128 in DSP format.
- R6: With mclk_en_i=0, mclk_o stays low and bclk_o is the divided clock itself.
- R7: With dsp_i=0 (two-slot format), a frame is 32 bit periods long, or 64 when wide_i=1. fsync_o is low for the first half of the frame and high for the second half.
- R8: With dsp_i=1 (DSP format), a frame is 16 bit periods long, or 32 when wide_i=1. fsync_o is high for exactly one bit period per frame.
- R9: Configuration inputs are taken only while port_en_i is low. Changes made while it is high have no effect until the port is disabled and enabled again.
- R10: While the port is idle (port_en_i low, or cfg_err_o high), park_i=1 forces all three clock outputs low. park_i=0 holds their last levels. After port_en_i is sampled low, the running values are still written at that edge, and the idle behaviour applies from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| port_en_i | input | 1 | Port enable; high runs the divider |
| pre_i | input | 8 | Prescale field |
| odd_i | input | 1 | Odd-adjust bit |
| mclk_en_i | input | 1 | Master clock output enable |
| wide_i | input | 1 | Channel length: 1 doubles frame length |
| dsp_i | input | 1 | Frame format: 0 two-slot, 1 DSP pulse |
| park_i | input | 1 | Force outputs low while idle |
| mclk_o | output | 1 | Master clock level |
| bclk_o | output | 1 | Bit clock level |
| fsync_o | output | 1 | Frame clock level |
| cfg_err_o | output | 1 | Illegal divider setting flag |

## Verification
Configuration fields enter the shadow at the first edge that sees port_en_i low, and cfg_err_o follows at that same edge. Reset clears the outputs one edge later. Park forcing takes effect at the second edge after the enable is dropped. The bench samples on the falling edge right after the edge where each result is due. The clock waveforms begin with a start phase that depends on the enable timing, so the bench discards every run up to the first transition and the final partial run. It then compares each complete high and low run length, in kernel cycles, against the expected value. Under this scheme, a constant output is one that shows no transition at all over a window covering three full frames.

// File: rtl/acd_pkg.sv
package acd_pkg;

  localparam int unsigned PRE_W         = 8;
  localparam int unsigned CNT_W         = PRE_W + 1;
  localparam int unsigned STD_SLOT_BITS = 32;
  localparam int unsigned DSP_SLOT_BITS = 16;
  localparam int unsigned STD_MCLK_FS   = 256;
  localparam int unsigned DSP_MCLK_FS   = 128;
  localparam int unsigned MAX_FRAME     = 2 * STD_SLOT_BITS;
  localparam int unsigned FRAME_W       = $clog2(MAX_FRAME) + 1;
  localparam int unsigned MAX_POST      = STD_MCLK_FS / STD_SLOT_BITS;
  localparam int unsigned POST_W        = $clog2(MAX_POST) + 1;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             odd;
    logic             mclk_en;
    logic             wide;
    logic             dsp;
  } cfg_t;

  // Division ratio; an all-zero setting bypasses (ratio one).
  function automatic logic [CNT_W-1:0] f_ratio(input logic [PRE_W-1:0] pre, input logic odd);
    logic [CNT_W-1:0] r;
    r = {pre, 1'b0} + CNT_W'(odd);
    return (r == '0) ? CNT_W'(1) : r;
  endfunction

  // High phase length: ceil(ratio/2).
  function automatic logic [CNT_W-1:0] f_high(input logic [CNT_W-1:0] r);
    logic [CNT_W:0] t;
    t = {1'b0, r} + 1'b1;
    return t[CNT_W:1];
  endfunction

  function automatic logic f_illegal(input logic [PRE_W-1:0] pre, input logic odd);
    return (pre == PRE_W'(1)) && odd;
  endfunction

  function automatic logic [FRAME_W-1:0] f_frame_bits(input logic dsp, input logic wide);
    int unsigned b;
    b = dsp ? DSP_SLOT_BITS : STD_SLOT_BITS;
    if (wide) b = b * 2;
    return FRAME_W'(b);
  endfunction

  function automatic logic [POST_W-1:0] f_post(input logic dsp, input logic wide);
    int unsigned m;
    m = dsp ? DSP_MCLK_FS : STD_MCLK_FS;
    return POST_W'(m / int'(f_frame_bits(dsp, wide)));
  endfunction

endpackage

// File: rtl/acd_cfg_hold.sv
module acd_cfg_hold
  import acd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic err_o
);

  cfg_t shadow_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       shadow_q <= '0;
    else if (load_i) shadow_q <= cfg_i;
  end

  assign cfg_o = shadow_q;
  assign err_o = f_illegal(shadow_q.pre, shadow_q.odd);

endmodule

// File: rtl/acd_prescale.sv
module acd_prescale #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         active_i,
  input  logic [W-1:0] ratio_i,
  input  logic [W-1:0] high_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o,
  output logic         lvl_o
);

  logic [W-1:0] cnt_q;

  assign tick_o = active_i && (cnt_q == ratio_i - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i || start_i)  cnt_q <= '0;
    else if (active_i)     cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign lvl_o = (cnt_q < high_i);

endmodule

// File: rtl/acd_post_stage.sv
module acd_post_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         bypass_i,
  input  logic [W-1:0] post_i,
  input  logic         plvl_i,
  output logic         tick_o,
  output logic         lvl_o
);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == post_i - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i || start_i)          cnt_q <= '0;
    else if (step_i && !bypass_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = bypass_i ? step_i : (step_i && wrap);
  assign lvl_o  = bypass_i ? plvl_i : (cnt_q < (post_i >> 1));

endmodule

// File: rtl/acd_frame_stage.sv
module acd_frame_stage #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         dsp_i,
  input  logic [W-1:0] bits_i,
  output logic         lvl_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || start_i) cnt_q <= '0;
    else if (step_i)      cnt_q <= (cnt_q == bits_i - 1'b1) ? '0 : cnt_q + 1'b1;
  end

  assign lvl_o = dsp_i ? (cnt_q == '0) : (cnt_q >= (bits_i >> 1));

endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div
  import acd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             port_en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             wide_i,
  input  logic             dsp_i,
  input  logic             park_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             cfg_err_o
);

  localparam int unsigned NOUT = 3;

  cfg_t cfg_in, cfg_q;
  logic cfg_err;
  logic run_q, start_w, active_w;
  logic [CNT_W-1:0]   ratio_w, high_w, pcnt_w;
  logic               ptick_w, plvl_w;
  logic [POST_W-1:0]  post_w;
  logic               btick_w, blvl_w;
  logic [FRAME_W-1:0] fbits_w;
  logic               flvl_w;
  logic               cfg_mclk_w;
  logic [$bits(cfg_t)-1:0] cfg_bits_w;
  logic [NOUT-1:0]    lvl_next, out_q;

  assign cfg_in = '{pre: pre_i, odd: odd_i, mclk_en: mclk_en_i, wide: wide_i, dsp: dsp_i};

  acd_cfg_hold u_cfg (
    .clk_i (clk_i), .rst_i (rst_i), .load_i (!port_en_i),
    .cfg_i (cfg_in), .cfg_o (cfg_q), .err_o (cfg_err)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) run_q <= 1'b0;
    else       run_q <= port_en_i;
  end

  assign start_w    = port_en_i && !run_q;
  assign active_w   = run_q && !cfg_err;
  assign ratio_w    = f_ratio(cfg_q.pre, cfg_q.odd);
  assign high_w     = f_high(ratio_w);
  assign post_w     = f_post(cfg_q.dsp, cfg_q.wide);
  assign fbits_w    = f_frame_bits(cfg_q.dsp, cfg_q.wide);
  assign cfg_mclk_w = cfg_q.mclk_en;
  assign cfg_bits_w = cfg_q;

  acd_prescale #(.W(CNT_W)) u_pre (
    .clk_i (clk_i), .rst_i (rst_i), .start_i (start_w), .active_i (active_w),
    .ratio_i (ratio_w), .high_i (high_w),
    .cnt_o (pcnt_w), .tick_o (ptick_w), .lvl_o (plvl_w)
  );

  acd_post_stage #(.W(POST_W)) u_post (
    .clk_i (clk_i), .rst_i (rst_i), .start_i (start_w), .step_i (ptick_w),
    .bypass_i (!cfg_q.mclk_en), .post_i (post_w), .plvl_i (plvl_w),
    .tick_o (btick_w), .lvl_o (blvl_w)
  );

  acd_frame_stage #(.W(FRAME_W)) u_frame (
    .clk_i (clk_i), .rst_i (rst_i), .start_i (start_w), .step_i (btick_w),
    .dsp_i (cfg_q.dsp), .bits_i (fbits_w), .lvl_o (flvl_w)
  );

  assign lvl_next = {cfg_q.mclk_en && plvl_w, blvl_w, flvl_w};

  // One output register lane per clock output.
  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk_i) begin
      if (rst_i)         out_q[g] <= 1'b0;
      else if (active_w) out_q[g] <= lvl_next[g];
      else if (park_i)   out_q[g] <= 1'b0;
    end
  end

  assign mclk_o    = out_q[2];
  assign bclk_o    = out_q[1];
  assign fsync_o   = out_q[0];
  assign cfg_err_o = cfg_err;

endmodule

// File: rtl/aud_clk_div_chk.sv
module aud_clk_div_chk
  import acd_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    port_en_i,
  input logic                    park_i,
  input logic [PRE_W-1:0]        pre_i,
  input logic                    odd_i,
  input logic                    mclk_o,
  input logic                    bclk_o,
  input logic                    fsync_o,
  input logic                    cfg_err_o,
  input logic                    active_w,
  input logic                    cfg_mclk_w,
  input logic [$bits(cfg_t)-1:0] cfg_bits_w,
  input logic [CNT_W-1:0]        ratio_w,
  input logic [CNT_W-1:0]        pcnt_w,
  input logic                    ptick_w,
  input logic                    btick_w
);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    rst_i |=> (!mclk_o && !bclk_o && !fsync_o && !cfg_err_o));

  assert_count_in_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    active_w |-> (pcnt_w < ratio_w));

  assert_illegal_flag_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!port_en_i && pre_i == PRE_W'(1) && odd_i) |=> cfg_err_o);

  assert_err_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_err_o && park_i) |=> (!mclk_o && !bclk_o && !fsync_o));

  assert_bit_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    btick_w |-> ptick_w);

  assert_no_mclk_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_w && !cfg_mclk_w) |=> !mclk_o);

  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    port_en_i |=> $stable(cfg_bits_w));

  assert_park_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!active_w && park_i) |=> (!mclk_o && !bclk_o && !fsync_o));

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!active_w && !park_i) |=> $stable({mclk_o, bclk_o, fsync_o}));

endmodule

bind aud_clk_div aud_clk_div_chk u_chk (
  .clk_i (clk_i), .rst_i (rst_i), .port_en_i (port_en_i), .park_i (park_i),
  .pre_i (pre_i), .odd_i (odd_i),
  .mclk_o (mclk_o), .bclk_o (bclk_o), .fsync_o (fsync_o), .cfg_err_o (cfg_err_o),
  .active_w (active_w), .cfg_mclk_w (cfg_mclk_w), .cfg_bits_w (cfg_bits_w),
  .ratio_w (ratio_w), .pcnt_w (pcnt_w), .ptick_w (ptick_w), .btick_w (btick_w)
);

// File: tb/tb_aud_clk_div.sv
module tb_aud_clk_div;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       port_en_i = 1'b0;
  logic [7:0] pre_i = '0;
  logic       odd_i = 1'b0, mclk_en_i = 1'b0, wide_i = 1'b0, dsp_i = 1'b0;
  logic       park_i = 1'b1;
  logic       mclk_o, bclk_o, fsync_o, cfg_err_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam int WATCHDOG = 150000;
  localparam int NV = 8;
  // pre, odd, mclk_en, wide, dsp | mclk hi/lo | bclk hi/lo | fsync hi/lo
  // a high length of 0 means the output must stay constant at the "lo" level
  localparam int VT [NV][11] = '{
    '{2, 0, 0, 0, 0,   0, 0,   2,  2,   64,  64},
    '{2, 1, 0, 1, 0,   0, 0,   3,  2,  160, 160},
    '{0, 0, 0, 0, 1,   0, 0,   0,  1,    1,  15},
    '{1, 0, 1, 0, 0,   1, 1,   8,  8,  256, 256},
    '{0, 1, 1, 1, 1,   0, 1,   2,  2,    4, 124},
    '{3, 1, 1, 0, 1,   4, 3,  28, 28,   56, 840},
    '{4, 0, 0, 1, 1,   0, 0,   4,  4,    8, 248},
    '{2, 0, 1, 1, 0,   2, 2,   8,  8,  512, 512}
  };

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aud_clk_div dut (
    .clk_i (clk), .rst_i (rst_i), .port_en_i (port_en_i), .pre_i (pre_i),
    .odd_i (odd_i), .mclk_en_i (mclk_en_i), .wide_i (wide_i), .dsp_i (dsp_i),
    .park_i (park_i), .mclk_o (mclk_o), .bclk_o (bclk_o), .fsync_o (fsync_o),
    .cfg_err_o (cfg_err_o)
  );

  function automatic logic pick(input int sel);
    case (sel)
      0:       return mclk_o;
      1:       return bclk_o;
      default: return fsync_o;
    endcase
  endfunction

  task automatic expect_bit(input string req, input string what, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Compare complete high/low run lengths of one output over a window.
  task automatic check_runs(input string req, input string what, input int sel,
                            input int hi_e, input int lo_e, input int window);
    logic prev, cur;
    int run = 1, edges = 0, n_hi = 0, n_lo = 0, bad = 0, got_hi = -1, got_lo = -1;
    bit seen = 1'b0, ok;
    @(negedge clk);
    prev = pick(sel);
    cur = prev;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      cur = pick(sel);
      if (cur == prev) run++;
      else begin
        edges++;
        if (seen) begin
          if (prev) begin n_hi++; got_hi = run; if (run != hi_e) bad++; end
          else      begin n_lo++; got_lo = run; if (run != lo_e) bad++; end
        end
        seen = 1'b1;
        run = 1;
        prev = cur;
      end
    end
    compared++;
    if (hi_e == 0) ok = (edges == 0) && (cur == lo_e[0]);
    else           ok = (bad == 0) && (n_hi > 0) && (n_lo > 0);
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: high %0d low %0d edges %0d level %0b expected high %0d low %0d",
               req, what, got_hi, got_lo, edges, cur, hi_e, lo_e);
    end
  endtask

  task automatic configure(input int pre, input int odd, input int men, input int wide, input int dsp);
    @(negedge clk);
    port_en_i = 1'b0;
    pre_i = pre[7:0]; odd_i = odd[0]; mclk_en_i = men[0]; wide_i = wide[0]; dsp_i = dsp[0];
    repeat (3) @(negedge clk);
    port_en_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic snap_m, snap_b, snap_f;
    int zeros_bad;
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    // R1: reset state
    expect_bit("R1", "mclk after reset", mclk_o, 1'b0);
    expect_bit("R1", "bclk after reset", bclk_o, 1'b0);
    expect_bit("R1", "fsync after reset", fsync_o, 1'b0);
    expect_bit("R1", "cfg_err after reset", cfg_err_o, 1'b0);

    // Vector table: R2, R3, R5, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      int win;
      string rm, rb, rf;
      win = 3 * (VT[v][9] + VT[v][10]) + 2 * (VT[v][7] + VT[v][8]) + 20;
      configure(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4]);
      rm = (VT[v][2] != 0) ? "R5" : "R6";
      if (VT[v][7] == 0)      rb = "R3";
      else if (VT[v][2] != 0) rb = "R5";
      else                    rb = "R2";
      rf = (VT[v][4] != 0) ? "R8" : "R7";
      check_runs(rm, $sformatf("mclk vector %0d", v), 0, VT[v][5], VT[v][6], win);
      check_runs(rb, $sformatf("bclk vector %0d", v), 1, VT[v][7], VT[v][8], win);
      check_runs(rf, $sformatf("fsync vector %0d", v), 2, VT[v][9], VT[v][10], win);
    end

    // R4: illegal pair flags one edge after presentation while disabled
    @(negedge clk);
    port_en_i = 1'b0; pre_i = 8'd1; odd_i = 1'b1; mclk_en_i = 1'b1; wide_i = 1'b0; dsp_i = 1'b0;
    @(negedge clk);
    expect_bit("R4", "cfg_err on pre=1 odd=1", cfg_err_o, 1'b1);
    odd_i = 1'b0;
    @(negedge clk);
    expect_bit("R4", "cfg_err on pre=1 odd=0", cfg_err_o, 1'b0);
    odd_i = 1'b1;
    @(negedge clk);
    port_en_i = 1'b1;
    zeros_bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mclk_o || bclk_o || fsync_o) zeros_bad++;
    end
    compared++;
    if (zeros_bad != 0) begin
      mismatched++;
      $display("FAIL R4 quiet while illegal: got %0d active samples expected 0", zeros_bad);
    end

    // R9: changes while enabled are ignored until the next enable
    configure(2, 0, 0, 0, 0);
    @(negedge clk);
    pre_i = 8'd5;
    odd_i = 1'b1;
    pre_i = 8'd1;
    @(negedge clk);
    expect_bit("R9", "cfg_err with illegal write while enabled", cfg_err_o, 1'b0);
    pre_i = 8'd5; odd_i = 1'b0;
    check_runs("R9", "bclk keeps old ratio", 1, 2, 2, 60);
    @(negedge clk);
    port_en_i = 1'b0;
    repeat (3) @(negedge clk);
    port_en_i = 1'b1;
    repeat (4) @(negedge clk);
    check_runs("R9", "bclk takes new ratio after re-enable", 1, 5, 5, 80);

    // R10: hold when park is low, force low when park is high
    park_i = 1'b0;
    repeat (7) @(negedge clk);
    port_en_i = 1'b0;
    repeat (2) @(negedge clk);
    snap_m = mclk_o; snap_b = bclk_o; snap_f = fsync_o;
    repeat (30) @(negedge clk);
    expect_bit("R10", "bclk held while idle", bclk_o, snap_b);
    expect_bit("R10", "fsync held while idle", fsync_o, snap_f);
    expect_bit("R10", "mclk held while idle", mclk_o, snap_m);
    park_i = 1'b1;
    @(negedge clk);
    expect_bit("R10", "outputs parked low", mclk_o | bclk_o | fsync_o, 1'b0);

    // R1: reset in the middle of a run
    configure(1, 0, 1, 0, 0);
    repeat (5) @(negedge clk);
    rst_i = 1'b1;
    @(negedge clk);
    expect_bit("R1", "outputs after mid-run reset", mclk_o | bclk_o | fsync_o, 1'b0);
    rst_i = 1'b0;
    port_en_i = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule